// File: doc/BRIEF.md
# Doze clock divisor control

This block holds a 16-bit clock divisor configuration word and turns it into the controls that the clock tree uses. Software reads and writes the word through a simple register port. The port has a write strobe, two byte enables, write data and a read-back bus. An interrupt pulse input can drop the block out of doze by hardware.

The block drives a CPU clock-enable strobe. While doze is off, the strobe is high in every cycle. While doze is on, it pulses once every 2^n peripheral clock cycles, where n is the doze ratio code. The block also decodes the divide ratios for an internal RC oscillator postscaler and for a PLL output postscaler.

Two write interlocks keep the configuration consistent:
- The doze ratio cannot change while doze is enabled.
- Doze cannot be enabled with a ratio code of zero.

Top module: `doze_clkdiv`

## Requirements
- R1: After reset, the read-back word is 16'h3040 and cpu_ce_o is high in every cycle.
- R2: A write with reg_be_i[1] set updates only bits 15:8. A write with reg_be_i[0] set updates only bits 7:0. The field layout is:
  - bit 15: recover-on-interrupt
  - bits 14:12: doze ratio
  - bit 11: doze enable
  - bits 10:8: RC postscaler code
  - bits 7:6: PLL postscaler code
  - bits 4:0: PLL prescaler
- R3: While doze enable reads 0, cpu_ce_o is high in every cycle. While doze enable reads 1 with ratio code n, cpu_ce_o is high once every 2^n cycles. The first pulse is in the first cycle in which doze enable reads 1.
- R4: A write to the doze ratio field is ignored when doze enable is 1 before the write.
- R5: Doze enable is set by a write only if the ratio held after that same write is nonzero. A single write that sets enable and a nonzero ratio from the disabled state commits both.
- R6: When recover-on-interrupt is 1 and irq_i is high, doze enable reads 0 in the next cycle. This takes priority over a write in the same cycle.
- R7: When recover-on-interrupt is 0, irq_i has no effect on doze enable.
- R8: Bit 5 always reads 0, whatever is written to it.
- R9: pll_div_o is 2, 4 or 8 for PLL codes 00, 01 and 11. A write of code 10 keeps the previous code.
- R10: rc_div_o is 2^k for RC code k from 0 to 6, and 256 for code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 2 | Byte enables (bit 1: high byte) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read-back of the configuration word |
| irq_i | input | 1 | Interrupt pulse |
| cpu_ce_o | output | 1 | CPU clock-enable strobe |
| rc_div_o | output | 9 | Decoded RC postscaler divide ratio |
| pll_div_o | output | 4 | Decoded PLL postscaler divide ratio |

## Verification
The bench builds the block with its default parameters: a 3-bit ratio field and therefore a 7-bit doze counter. With these values the longest strobe period is only 128 cycles, so every doze ratio code can have its strobe period measured over three full periods. The same small fields let the bench sweep all eight RC codes and all four PLL codes, including the reserved one. The interlock and interrupt cases are each driven from both enable states.

// File: rtl/doze_pkg.sv
package doze_pkg;
  localparam int WORD_W  = 16;
  localparam int RATIO_W = 3;
  localparam int RC_W    = 3;
  localparam int PLL_W   = 2;
  localparam int PRE_W   = 5;
  localparam int BYTE_N  = WORD_W / 8;

  localparam logic [PLL_W-1:0]  PLL_RSVD  = 2'b10;
  localparam logic [WORD_W-1:0] CFG_RESET = 16'h3040;

  typedef struct packed {
    logic               roi;
    logic [RATIO_W-1:0] ratio;
    logic               en;
    logic [RC_W-1:0]    rc;
    logic [PLL_W-1:0]   pll;
    logic               rsvd;
    logic [PRE_W-1:0]   pre;
  } cfg_t;
endpackage

// File: rtl/doze_cfg_reg.sv
module doze_cfg_reg
  import doze_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_N-1:0] be_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              irq_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_d, wr;

  assign wr = cfg_t'(wdata_i);

  always_comb begin
    cfg_d = cfg_q;
    if (we_i && be_i[1]) begin
      cfg_d.roi = wr.roi;
      cfg_d.rc  = wr.rc;
      // ratio locked while doze runs; enable checked against committed ratio
      if (!cfg_q.en) cfg_d.ratio = wr.ratio;
      cfg_d.en = wr.en && (cfg_d.ratio != '0);
    end
    if (we_i && be_i[0]) begin
      if (wr.pll != PLL_RSVD) cfg_d.pll = wr.pll;
      cfg_d.pre = wr.pre;
    end
    cfg_d.rsvd = 1'b0;
    if (irq_i && cfg_q.roi) cfg_d.en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= cfg_t'(CFG_RESET);
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/doze_strobe.sv
module doze_strobe #(
  parameter int RATIO_W = 3,
  localparam int CNT_W  = (1 << RATIO_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               ce_o
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim, cnt_q;

  assign span = (CNT_W+1)'(1) << ratio_i;
  assign lim  = CNT_W'(span - (CNT_W+1)'(1));

  // held at zero while idle, so each enable starts a fresh period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign ce_o = !en_i || (cnt_q == '0);
endmodule

// File: rtl/doze_div_decode.sv
module doze_div_decode #(
  parameter int RC_W  = 3,
  parameter int PLL_W = 2,
  localparam int RC_DIV_W  = (1 << RC_W) + 1,
  localparam int PLL_DIV_W = (1 << PLL_W),
  localparam int RC_SH_W   = RC_W + 1,
  localparam int PLL_SH_W  = PLL_W + 1
) (
  input  logic [RC_W-1:0]      rc_i,
  input  logic [PLL_W-1:0]     pll_i,
  output logic [RC_DIV_W-1:0]  rc_div_o,
  output logic [PLL_DIV_W-1:0] pll_div_o
);
  logic [RC_SH_W-1:0]  rc_sh;
  logic [PLL_SH_W-1:0] pll_sh;

  // top RC code skips one octave
  assign rc_sh  = (rc_i == '1) ? RC_SH_W'(rc_i) + RC_SH_W'(1) : RC_SH_W'(rc_i);
  assign pll_sh = (pll_i == '1) ? PLL_SH_W'(pll_i) : PLL_SH_W'(pll_i) + PLL_SH_W'(1);

  assign rc_div_o  = RC_DIV_W'(1) << rc_sh;
  assign pll_div_o = PLL_DIV_W'(1) << pll_sh;
endmodule

// File: rtl/doze_clkdiv.sv
module doze_clkdiv
  import doze_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_be_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        irq_i,
  output logic        cpu_ce_o,
  output logic [8:0]  rc_div_o,
  output logic [3:0]  pll_div_o
);
  cfg_t cfg;

  doze_cfg_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .irq_i   (irq_i),
    .cfg_o   (cfg)
  );

  doze_strobe #(.RATIO_W(RATIO_W)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.en),
    .ratio_i (cfg.ratio),
    .ce_o    (cpu_ce_o)
  );

  doze_div_decode #(.RC_W(RC_W), .PLL_W(PLL_W)) u_dec (
    .rc_i      (cfg.rc),
    .pll_i     (cfg.pll),
    .rc_div_o  (rc_div_o),
    .pll_div_o (pll_div_o)
  );

  assign reg_rdata_o = cfg;
endmodule

// File: rtl/doze_clkdiv_chk.sv
module doze_clkdiv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [15:0] reg_rdata_o,
  input logic        irq_i,
  input logic        cpu_ce_o
);
  p_idle_full_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[11] |-> cpu_ce_o);

  p_ratio_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[11] |=> $stable(reg_rdata_o[14:12]));

  p_en_needs_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[11] |-> (reg_rdata_o[14:12] != 3'b000));

  p_irq_recover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && reg_rdata_o[15]) |=> !reg_rdata_o[11]);

  p_irq_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !reg_rdata_o[15] && !reg_we_i && reg_rdata_o[11]) |=> reg_rdata_o[11]);

  p_bit5_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[5]);

  p_no_rsvd_pll_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:6] != 2'b10);
endmodule

bind doze_clkdiv doze_clkdiv_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_i       (irq_i),
  .cpu_ce_o    (cpu_ce_o)
);

// File: tb/tb_doze_clkdiv.sv
module tb_doze_clkdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq = 1'b0;
  logic        ce;
  logic [8:0]  rc_div;
  logic [3:0]  pll_div;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  doze_clkdiv dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_i(irq),
    .cpu_ce_o(ce), .rc_div_o(rc_div), .pll_div_o(pll_div)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = 2'b00;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
  endtask

  // roi | ratio | en | rc | pll | pre
  function automatic logic [15:0] word(logic roi, logic [2:0] r, logic en,
                                       logic [2:0] rc, logic [1:0] pll);
    return {roi, r, en, rc, pll, 1'b0, 5'd0};
  endfunction

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h3040, "R1 reset word", rdata, 16'h3040);
    begin
      int hi = 0;
      for (int i = 0; i < 8; i++) begin
        if (ce) hi++;
        @(negedge clk);
      end
      chk(hi == 8, "R1 ce every cycle after reset", hi, 8);
    end

    // R2 byte enables
    wr(2'b01, 16'hFFDF);
    chk(rdata == 16'h30DF, "R2 low byte only", rdata, 16'h30DF);
    wr(2'b10, 16'h0500);
    chk(rdata == 16'h05DF, "R2 high byte only", rdata, 16'h05DF);

    // R8 bit 5
    wr(2'b11, 16'h7F20);
    chk(rdata[5] == 1'b0, "R8 bit5 reads zero", rdata[5], 0);
    wr(2'b10, word(0, 3'd1, 0, 0, 0));

    // R10 RC sweep
    for (int k = 0; k < 8; k++) begin
      int exp_rc;
      exp_rc = (k == 7) ? 256 : (1 << k);
      wr(2'b10, word(0, 3'd1, 0, 3'(k), 0));
      chk(rc_div == 9'(exp_rc), $sformatf("R10 rc code %0d", k), rc_div, exp_rc);
    end

    // R9 PLL sweep incl. reserved
    wr(2'b01, 16'h0000);
    chk(pll_div == 4'd2, "R9 pll 00", pll_div, 2);
    wr(2'b01, 16'h0080);
    chk(rdata[7:6] == 2'b00 && pll_div == 4'd2, "R9 reserved keeps 00", rdata[7:6], 0);
    wr(2'b01, 16'h0040);
    chk(pll_div == 4'd4, "R9 pll 01", pll_div, 4);
    wr(2'b01, 16'h00C0);
    chk(pll_div == 4'd8, "R9 pll 11", pll_div, 8);
    wr(2'b01, 16'h0080);
    chk(rdata[7:6] == 2'b11 && pll_div == 4'd8, "R9 reserved keeps 11", rdata[7:6], 3);

    // R3 strobe period for every ratio code (R5 combined set+ratio)
    for (int n = 1; n < 8; n++) begin
      int bad = 0;
      int per;
      per = 1 << n;
      wr(2'b10, word(0, 3'(n), 1, 0, 0));
      chk(rdata[11] && rdata[14:12] == 3'(n), $sformatf("R5 set en with ratio %0d", n),
          rdata[14:11], {n[2:0], 1'b1});
      for (int i = 0; i < 3 * per; i++) begin
        if (ce != ((i % per) == 0)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, $sformatf("R3 ce period code %0d", n), bad, 0);
      wr(2'b10, word(0, 3'(n), 0, 0, 0));
      chk(ce == 1'b1, "R3 ce full rate after disable", ce, 1);
    end

    // R3 code 0 with enable attempt: full rate, enable refused (R5)
    wr(2'b10, word(0, 3'd0, 0, 0, 0));
    wr(2'b10, word(0, 3'd0, 1, 0, 0));
    chk(rdata[11] == 1'b0, "R5 enable refused with ratio 0", rdata[11], 0);
    chk(ce == 1'b1, "R3 ce full rate at ratio 0", ce, 1);

    // R4 ratio locked while enabled
    wr(2'b10, word(0, 3'd3, 1, 0, 0));
    wr(2'b10, word(0, 3'd5, 1, 0, 0));
    chk(rdata[14:12] == 3'd3 && rdata[11], "R4 ratio write ignored", rdata[14:12], 3);
    wr(2'b10, word(0, 3'd0, 1, 0, 0));
    chk(rdata[14:12] == 3'd3 && rdata[11], "R4 zero ratio write ignored", rdata[14:12], 3);
    wr(2'b10, word(0, 3'd6, 0, 0, 0));
    chk(rdata[14:12] == 3'd3 && !rdata[11], "R4 locked on disabling write", rdata[14:12], 3);
    wr(2'b10, word(0, 3'd6, 0, 0, 0));
    chk(rdata[14:12] == 3'd6, "R4 ratio write accepted when idle", rdata[14:12], 6);

    // R7 irq ignored with roi=0
    wr(2'b10, word(0, 3'd2, 1, 0, 0));
    pulse_irq();
    chk(rdata[11] == 1'b1, "R7 irq no effect", rdata[11], 1);

    // R6 irq clears with roi=1
    wr(2'b10, word(1, 3'd2, 1, 0, 0));
    chk(rdata[11] && rdata[15], "R6 setup", rdata[15:11], 5'h15);
    pulse_irq();
    chk(rdata[11] == 1'b0, "R6 irq clears enable", rdata[11], 0);
    chk(ce == 1'b1, "R6 ce full rate after recover", ce, 1);

    // R6 priority over simultaneous enabling write
    @(negedge clk);
    we = 1'b1; be = 2'b10; wdata = word(1, 3'd2, 1, 0, 0); irq = 1'b1;
    @(negedge clk);
    we = 1'b0; be = 2'b00; irq = 1'b0;
    chk(rdata[11] == 1'b0, "R6 irq beats write", rdata[11], 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule